// File: doc/BRIEF.md
# Serial Gain-Control Register Interface

This block takes gain settings for a transmit attenuator and a two-stage receive amplifier over a three-wire serial link: an active-low select, a serial clock and a data line, plus a reset pin. While the select is low, the block shifts in one data bit on each rising edge of the serial clock. When the select goes high after exactly sixteen bits, the block treats the bits as one write frame. The frame carries a register address and a data byte. The frame updates either the transmit register or the receive register, or it is dropped.

All three serial lines pass through flip-flop synchronizers into the system clock domain, and all of the logic runs on that clock. The block exposes the raw contents of both registers and a one-cycle pulse for each register write. It also exposes three signed dB values decoded from the register fields, which feed the analog gain stages downstream.

Top module: `gain_serial_ctrl`

## Requirements
- R1: While `rst` is high, both registers read 0x00 and `upd` is low. The decoded gains are then transmit 0 dB, first receive 0 dB and second receive -9 dB.
- R2: Wire bit k of a frame is the k-th bit sampled on a rising edge of `ser_clk` while `ser_cs_n` is low. Bit 0 is padding. Bits 1..4 carry address bits A0..A3, in that order. Bits 5..7 are padding. Bits 8..15 carry data bits D0..D7, least significant first.
- R3: With A1=0, the value of A0 selects the register: A0=0 writes the transmit register and A0=1 writes the receive register. A2 and A3 have no effect on which register is written.
- R4: A frame with A1=1 changes neither register and raises no `upd` pulse.
- R5: A frame with fewer or more than 16 clocked bits is discarded: no register changes and no pulse.
- R6: The transmit gain comes from bits 2..0 of the transmit register. Codes 0 to 5 give -2 dB times the code. Codes 6 and 7 both give -12 dB. Bits 7..3 are ignored.
- R7: The first receive gain comes from bits 3..0 of the receive register. When bit 3 is 0, the gain is 3 dB times bits 2..0. When bit 3 is 1, the gain is 24 dB.
- R8: The second receive gain comes from bits 7..4 of the receive register. When bit 7 is 0, the gain is -9 dB plus 3 dB times bits 6..4. When bit 7 is 1, bits 6..5 are ignored: bit 4 = 0 gives 15 dB and bit 4 = 1 gives 18 dB.
- R9: Each accepted frame produces exactly one `upd` pulse, one system clock wide. The pulse appears in the same cycle that the new register value first appears on the outputs.
- R10: Asserting `rst` in the middle of a frame drops the bits already received, so the rest of that frame counts as a short frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset for the interface and the registers |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data | input | 1 | Serial data line |
| ser_cs_n | input | 1 | Active-low frame select |
| tx_reg | output | 8 | Raw transmit register |
| rx_reg | output | 8 | Raw receive register |
| tx_gain_db | output | 6 | Signed transmit gain in dB |
| rx1_gain_db | output | 6 | Signed first-stage receive gain in dB |
| rx2_gain_db | output | 6 | Signed second-stage receive gain in dB |
| upd | output | 1 | One-cycle pulse on each register write |

## Verification
One system clock cycle carries two decisions: accepting the frame and clearing the bit counter. Both happen when the synchronized select is first seen high. The counter must still hold its final count when the block judges the frame length, and it must reach zero before the next frame starts. The bench drives frames of exactly 15, 16 and 17 bits, then a full frame straight after each of them. It expects a pulse and a new register value only for the 16-bit frames. A scoreboard checks that no other write pulses appear.

// File: rtl/gsc_pkg.sv
`timescale 1ns/1ps
package gsc_pkg;
   localparam int FRAME_LEN = 16;
   localparam int ADDR_LSB  = 1;
   localparam int ADDR_W    = 4;
   localparam int DATA_LSB  = 8;
   localparam int DATA_W    = 8;
   localparam int GAIN_W    = 6;
   localparam int CNT_W     = $clog2(FRAME_LEN + 2);

   typedef logic signed [GAIN_W-1:0] gain_t;
   typedef logic [DATA_W-1:0]        byte_t;

   typedef enum logic [1:0] {
      SEL_TX   = 2'b00,
      SEL_RX   = 2'b01,
      SEL_NONE = 2'b10
   } reg_sel_e;
endpackage

// File: rtl/gsc_sync.sv
`timescale 1ns/1ps
module gsc_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gsc_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gsc_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gsc_deser.sv
`timescale 1ns/1ps
module gsc_deser
   import gsc_pkg::*;
#(
   parameter int LEN = FRAME_LEN,
   localparam int CW  = $clog2(LEN + 2),
   localparam logic [CW-1:0] CNT_MAX  = CW'(LEN + 1),
   localparam logic [CW-1:0] CNT_FULL = CW'(LEN)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           sclk_s,
   input  logic           sdi_s,
   input  logic           csn_s,
   output logic           frame_vld,
   output logic [LEN-1:0] frame_word
);
   if (LEN < 2) begin : g_bad_len
      $error("gsc_deser: LEN too small");
   end

   logic           sclk_q;
   logic           csn_q;
   logic [CW-1:0]  bit_cnt;
   logic [LEN-1:0] shreg;
   logic           sclk_rise;
   logic           cs_end;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign cs_end    = csn_s & ~csn_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sclk_q    <= 1'b0;
         csn_q     <= 1'b1;
         bit_cnt   <= '0;
         shreg     <= '0;
         frame_vld <= 1'b0;
      end else begin
         sclk_q    <= sclk_s;
         csn_q     <= csn_s;
         frame_vld <= 1'b0;
         if (csn_s) begin
            bit_cnt <= '0;
            if (cs_end && (bit_cnt == CNT_FULL)) frame_vld <= 1'b1;
         end else if (sclk_rise) begin
            shreg <= {sdi_s, shreg[LEN-1:1]};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign frame_word = shreg;
endmodule

// File: rtl/gsc_regfile.sv
`timescale 1ns/1ps
module gsc_regfile
   import gsc_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 frame_vld,
   input  logic [FRAME_LEN-1:0] frame_word,
   output byte_t                tx_reg,
   output byte_t                rx_reg,
   output logic                 upd
);
   logic [ADDR_W-1:0] addr;
   byte_t             data;
   reg_sel_e          sel;

   assign addr = frame_word[ADDR_LSB +: ADDR_W];
   assign data = frame_word[DATA_LSB +: DATA_W];

   always_comb begin
      unique case (addr[1:0])
         2'b00:   sel = SEL_TX;
         2'b01:   sel = SEL_RX;
         default: sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         tx_reg <= '0;
         rx_reg <= '0;
         upd    <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (frame_vld) begin
            case (sel)
               SEL_TX: begin
                  tx_reg <= data;
                  upd    <= 1'b1;
               end
               SEL_RX: begin
                  rx_reg <= data;
                  upd    <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gsc_gain_dec.sv
`timescale 1ns/1ps
module gsc_gain_dec
   import gsc_pkg::*;
(
   input  byte_t tx_reg,
   input  byte_t rx_reg,
   output gain_t tx_db,
   output gain_t rx1_db,
   output gain_t rx2_db
);
   localparam gain_t TX_FLOOR = -6'sd12;
   localparam gain_t RX1_TOP  = 6'sd24;
   localparam gain_t RX2_LOW  = -6'sd9;
   localparam gain_t RX2_HI0  = 6'sd15;
   localparam gain_t RX2_HI1  = 6'sd18;

   logic [2:0] tx_code;
   logic [2:0] rx1_code;
   logic [2:0] rx2_code;

   assign tx_code  = tx_reg[2:0];
   assign rx1_code = rx_reg[2:0];
   assign rx2_code = rx_reg[6:4];

   always_comb begin
      if (tx_code[2:1] == 2'b11) tx_db = TX_FLOOR;
      else                       tx_db = -$signed({2'b00, tx_code, 1'b0});
   end

   always_comb begin
      if (rx_reg[3]) rx1_db = RX1_TOP;
      else           rx1_db = $signed({2'b00, rx1_code, 1'b0}) + $signed({3'b000, rx1_code});
   end

   always_comb begin
      if (rx_reg[7]) rx2_db = rx_reg[4] ? RX2_HI1 : RX2_HI0;
      else           rx2_db = RX2_LOW + $signed({2'b00, rx2_code, 1'b0}) + $signed({3'b000, rx2_code});
   end
endmodule

// File: rtl/gain_serial_ctrl.sv
`timescale 1ns/1ps
module gain_serial_ctrl
   import gsc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        ser_clk,
   input  logic        ser_data,
   input  logic        ser_cs_n,
   output logic [7:0]  tx_reg,
   output logic [7:0]  rx_reg,
   output logic signed [5:0] tx_gain_db,
   output logic signed [5:0] rx1_gain_db,
   output logic signed [5:0] rx2_gain_db,
   output logic        upd
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gain_serial_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [2:0]           raw_in;
   logic [2:0]           sync_out;
   logic                 sclk_s;
   logic                 sdi_s;
   logic                 csn_s;
   logic                 frame_vld;
   logic [FRAME_LEN-1:0] frame_word;
   byte_t                tx_q;
   byte_t                rx_q;
   gain_t                tx_db;
   gain_t                rx1_db;
   gain_t                rx2_db;

   assign raw_in = {ser_cs_n, ser_data, ser_clk};

   gsc_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_in),
      .q   (sync_out)
   );

   assign sclk_s = sync_out[0];
   assign sdi_s  = sync_out[1];
   assign csn_s  = sync_out[2];

   gsc_deser #(.LEN(FRAME_LEN)) u_deser (
      .clk        (clk),
      .rst        (rst),
      .sclk_s     (sclk_s),
      .sdi_s      (sdi_s),
      .csn_s      (csn_s),
      .frame_vld  (frame_vld),
      .frame_word (frame_word)
   );

   gsc_regfile u_regs (
      .clk        (clk),
      .rst        (rst),
      .frame_vld  (frame_vld),
      .frame_word (frame_word),
      .tx_reg     (tx_q),
      .rx_reg     (rx_q),
      .upd        (upd)
   );

   gsc_gain_dec u_dec (
      .tx_reg (tx_q),
      .rx_reg (rx_q),
      .tx_db  (tx_db),
      .rx1_db (rx1_db),
      .rx2_db (rx2_db)
   );

   assign tx_reg      = tx_q;
   assign rx_reg      = rx_q;
   assign tx_gain_db  = tx_db;
   assign rx1_gain_db = rx1_db;
   assign rx2_gain_db = rx2_db;
endmodule

// File: rtl/gsc_chk.sv
`timescale 1ns/1ps
module gsc_chk (
   input logic              clk,
   input logic              rst,
   input logic [7:0]        tx_reg,
   input logic [7:0]        rx_reg,
   input logic signed [5:0] tx_gain_db,
   input logic signed [5:0] rx1_gain_db,
   input logic signed [5:0] rx2_gain_db,
   input logic              upd,
   input logic              frame_vld
);
   AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (rst)
      !upd |-> ($stable(tx_reg) && $stable(rx_reg)));                     // R4
   AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
      upd |=> !upd);                                                       // R9
   AST_UPD_FROM_FRAME: assert property (@(posedge clk) disable iff (rst)
      upd |-> $past(frame_vld));                                           // R5
   AST_TX_RANGE: assert property (@(posedge clk) disable iff (rst)
      (tx_gain_db <= 6'sd0) && (tx_gain_db >= -6'sd12) && !tx_gain_db[0]); // R6
   AST_RX1_RANGE: assert property (@(posedge clk) disable iff (rst)
      (rx1_gain_db >= 6'sd0) && (rx1_gain_db <= 6'sd24));                  // R7
   AST_RX2_RANGE: assert property (@(posedge clk) disable iff (rst)
      (rx2_gain_db >= -6'sd9) && (rx2_gain_db <= 6'sd18));                 // R8
endmodule

bind gain_serial_ctrl gsc_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .tx_reg      (tx_reg),
   .rx_reg      (rx_reg),
   .tx_gain_db  (tx_gain_db),
   .rx1_gain_db (rx1_gain_db),
   .rx2_gain_db (rx2_gain_db),
   .upd         (upd),
   .frame_vld   (frame_vld)
);

// File: tb/tb_gain_serial_ctrl.sv
`timescale 1ns/1ps
module tb_gain_serial_ctrl;
   typedef struct {
      logic [7:0]        tx;
      logic [7:0]        rx;
      logic signed [5:0] tdb;
      logic signed [5:0] r1;
      logic signed [5:0] r2;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_clk = 1'b0;
   logic ser_data = 1'b0;
   logic ser_cs_n = 1'b1;
   logic [7:0] tx_reg, rx_reg;
   logic signed [5:0] tx_gain_db, rx1_gain_db, rx2_gain_db;
   logic upd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_t sb[$];
   logic [7:0] m_tx = 8'h00;
   logic [7:0] m_rx = 8'h00;

   always #10 clk = ~clk;

   gain_serial_ctrl dut (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_cs_n(ser_cs_n),
      .tx_reg(tx_reg), .rx_reg(rx_reg), .tx_gain_db(tx_gain_db),
      .rx1_gain_db(rx1_gain_db), .rx2_gain_db(rx2_gain_db), .upd(upd)
   );

   function automatic logic signed [5:0] ref_tx(input logic [7:0] r);
      case (r[2:0])
         3'd0: return 0;   3'd1: return -2;  3'd2: return -4;  3'd3: return -6;
         3'd4: return -8;  3'd5: return -10; default: return -12;
      endcase
   endfunction

   function automatic logic signed [5:0] ref_rx1(input logic [7:0] r);
      if (r[3]) return 24;
      case (r[2:0])
         3'd0: return 0;  3'd1: return 3;  3'd2: return 6;  3'd3: return 9;
         3'd4: return 12; 3'd5: return 15; 3'd6: return 18; default: return 21;
      endcase
   endfunction

   function automatic logic signed [5:0] ref_rx2(input logic [7:0] r);
      if (r[7]) return r[4] ? 6'sd18 : 6'sd15;
      case (r[6:4])
         3'd0: return -9; 3'd1: return -6; 3'd2: return -3; 3'd3: return 0;
         3'd4: return 3;  3'd5: return 6;  3'd6: return 9;  default: return 12;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver: sends a frame of nbits bits and pushes the expected result.
   task automatic send(input logic [3:0] a, input logic [7:0] d, input int nbits);
      logic [15:0] w;
      exp_t e;
      w = {d, 3'b000, a, 1'b0};
      ser_cs_n = 1'b0;
      wclk(4);
      for (int i = 0; i < nbits; i++) begin
         ser_data = (i < 16) ? w[i] : 1'b0;
         ser_clk  = 1'b0;
         wclk(5);
         ser_clk  = 1'b1;
         wclk(5);
      end
      ser_clk = 1'b0;
      wclk(4);
      if (nbits == 16 && a[1] == 1'b0) begin
         if (a[0]) m_rx = d; else m_tx = d;
         e.tx = m_tx; e.rx = m_rx;
         e.tdb = ref_tx(m_tx); e.r1 = ref_rx1(m_rx); e.r2 = ref_rx2(m_rx);
         sb.push_back(e);
      end
      ser_cs_n = 1'b1;
      wclk(14);
      check(tx_reg == m_tx, "R4/R5", "tx_reg after frame", tx_reg, m_tx);
      check(rx_reg == m_rx, "R4/R5", "rx_reg after frame", rx_reg, m_rx);
   endtask

   // Monitor: pops the scoreboard on every update pulse.
   always @(negedge clk) begin
      if (!rst && upd) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9", "unexpected upd pulse", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(tx_reg == e.tx, "R2/R3", "tx_reg", tx_reg, e.tx);
            check(rx_reg == e.rx, "R2/R3", "rx_reg", rx_reg, e.rx);
            check(tx_gain_db == e.tdb, "R6", "tx_gain_db", tx_gain_db, e.tdb);
            check(rx1_gain_db == e.r1, "R7", "rx1_gain_db", rx1_gain_db, e.r1);
            check(rx2_gain_db == e.r2, "R8", "rx2_gain_db", rx2_gain_db, e.r2);
         end
      end
   end

   initial begin
      #(64'd200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wclk(5);
      // R1 reset state
      check(tx_reg == 8'h00 && rx_reg == 8'h00, "R1", "regs in reset", {tx_reg, rx_reg}, 0);
      check(tx_gain_db == 0 && rx1_gain_db == 0, "R1", "tx/rx1 gain in reset", tx_gain_db, 0);
      check(rx2_gain_db == -9, "R1", "rx2 gain in reset", rx2_gain_db, -9);
      check(upd == 1'b0, "R1", "upd in reset", upd, 0);
      rst = 1'b0;
      wclk(5);

      // R6 all transmit codes, upper bits set to prove they are ignored
      for (int c = 0; c < 8; c++) send(4'b0000, 8'(c) | 8'hA8, 16);
      // R3 A2/A3 ignored for both registers
      send(4'b1100, 8'h03, 16);
      send(4'b0101, 8'h5A, 16);
      send(4'b1001, 8'h21, 16);
      // R7 R8 every receive value
      for (int v = 0; v < 256; v++) send(4'b0001, 8'(v), 16);
      // R4 A1=1 frames ignored
      send(4'b0010, 8'hFF, 16);
      send(4'b0011, 8'h00, 16);
      send(4'b1110, 8'h77, 16);
      // R5 short and long frames, each followed by a good one
      send(4'b0000, 8'h05, 15);
      send(4'b0000, 8'h02, 16);
      send(4'b0001, 8'h11, 17);
      send(4'b0001, 8'h34, 16);
      send(4'b0000, 8'h04, 1);
      send(4'b0000, 8'h01, 16);

      // R10 reset in mid-frame drops the partial frame
      ser_cs_n = 1'b0;
      wclk(4);
      for (int i = 0; i < 8; i++) begin
         ser_data = (i == 1); ser_clk = 1'b0; wclk(5); ser_clk = 1'b1; wclk(5);
      end
      ser_clk = 1'b0;
      rst = 1'b1; wclk(3); rst = 1'b0;
      m_tx = 8'h00; m_rx = 8'h00;
      for (int i = 0; i < 8; i++) begin
         ser_data = 1'b1; ser_clk = 1'b0; wclk(5); ser_clk = 1'b1; wclk(5);
      end
      ser_clk = 1'b0; wclk(4); ser_cs_n = 1'b1; wclk(14);
      check(tx_reg == 8'h00 && rx_reg == 8'h00, "R10", "regs after mid-frame reset",
            {tx_reg, rx_reg}, 0);
      send(4'b0001, 8'h96, 16);

      wclk(10);
      check(sb.size() == 0, "R9", "missing upd pulses", sb.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule